// File: doc/BRIEF.md
# MDIO Management Master

This block manages a PHY over the two-wire MDC/MDIO management bus. Software fills in one 32-bit control word, and for extended-address accesses also a second word that holds the device address and a 16-bit register address. Setting the start bit launches one read or one write. Plain (Clause 22) accesses send a single frame. Extended (Clause 45) accesses send an address frame and then a data frame. While the bus is in use, busy reads as 1. At the end of a read, the 16 bits returned by the PHY replace the data field of the control word.

MDC runs at the block clock divided by a ratio that a 3-bit code selects. The 32-bit preamble can be suppressed to shorten each frame. An auto-poll bit makes the block read PHY register 1 over and over while no manual access is pending. The PHY address and the port address sent on the wire are always 0.

Top module: `mdio_master`

## Requirements
- R1: After reset, both register read ports return 0, MDC is low and MDIO is not driven.
- R2: Control word layout: [15:0] data, [20:16] register, [21] read (1) or write (0), [22] preamble suppress, [23] start, [26:24] clock select, [27] busy (read-only), [28] auto-poll, [29] post-read flag (stored only), [30] extended mode. Writable fields read back as written. After a start is written, start reads 1 and busy reads 0 for one cycle. In the next cycle start reads 0 and busy reads 1.
- R3: MDC period in block clocks is 4, 4, 6, 8, 10, 32, 64 or 128 for clock-select codes 0 through 7 (code 1 counts as 4). A suppressed-preamble frame keeps busy high for 32 MDC periods.
- R4: A plain write sends, MSB first: 01, 01, PHY address 00000, the 5-bit register, 10, and then the 16 data bits.
- R5: A plain read drives 01, 10, 00000 and the register, then releases MDIO for the turnaround and 16 data bits. Once busy falls, the sampled value appears in control bits [15:0].
- R6: When preamble suppress is 0, 32 driven ones come before each frame, and busy lasts 64 MDC periods.
- R7: Extended word layout: [15:0] register address, [20:16] device address, [25:21] port field (stored, but sent as 0). An extended write sends 00,00,00000,dev,10,reg16 and then 00,01,00000,dev,10,data.
- R8: An extended read sends the same address frame, then 00,11,00000,dev. It releases MDIO for the turnaround and data, and returns the data in control bits [15:0].
- R9: With auto-poll set and start clear, the block reads register 1 repeatedly and refreshes the data field each time. Writing the control word to 0 stops polling once the current frame ends.
- R10: MDIO output and output enable change only while MDC is low, and never in the cycle MDC rises.
- R11: Whenever busy is 0, MDC is low and MDIO is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock from which MDC is divided |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 32 | Control word write data |
| ext_we | input | 1 | Write strobe for the extended-address word |
| ext_wdata | input | 32 | Extended-address word write data |
| ctrl_rdata | output | 32 | Control word readback, including busy and read result |
| ext_rdata | output | 32 | Extended-address word readback |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable (0 releases the line) |
| mdio_i | input | 1 | MDIO line as seen at the pad |

## Verification
Most internal faults in this block show up on the wire. A wrong bit counter or frame-select flag gives the wrong number of driven MDC edges or wrong frame bits. The bench captures every driven bit on the rising edges of MDC and compares the whole sequence. A wrong divider entry or phase counter shows up within the first two MDC rising edges as a wrong period, and as a wrong busy length by the end of the frame. A wrong sampling point or shift order leaves a wrong value in the data field in the first cycle after busy falls.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int PRE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctrl_we,
  input  logic [31:0] ctrl_wdata,
  input  logic        ext_we,
  input  logic [31:0] ext_wdata,
  output logic [31:0] ctrl_rdata,
  output logic [31:0] ext_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int FRM = 32;
  localparam int BW  = $clog2(PRE_LEN + FRM);
  localparam logic [BW-1:0] LAST_S = BW'(FRM - 1);
  localparam logic [BW-1:0] LAST_L = BW'(PRE_LEN + FRM - 1);

  logic [15:0] data_q;
  logic [4:0]  reg_q;
  logic        rd_q, sup_q, start_q, busy_q, ap_q, post_q, ext_q;
  logic [2:0]  cs_q;
  logic [4:0]  port_q, dev_q;
  logic [15:0] xreg_q;

  logic        t_rd, t_ext, t_sup, t_second;
  logic [4:0]  t_reg, t_dev;
  logic [15:0] t_xreg, t_wd;
  logic [6:0]  t_half, dcnt;
  logic [BW-1:0] bc;
  logic        phase;
  logic [15:0] rsh;
  logic [31:0] fw;

  function automatic logic [6:0] half_of(input logic [2:0] code);
    case (code)
      3'd2:    return 7'd3;
      3'd3:    return 7'd4;
      3'd4:    return 7'd5;
      3'd5:    return 7'd16;
      3'd6:    return 7'd32;
      3'd7:    return 7'd64;
      default: return 7'd2;
    endcase
  endfunction

  wire go_sw  = start_q && !busy_q;
  wire go_ap  = ap_q && !start_q && !busy_q;
  wire launch = go_sw || go_ap;
  wire tick   = busy_q && (dcnt == 7'd0);
  wire in_pre = bc >= BW'(FRM);
  wire [4:0] fidx = bc[4:0];
  wire data_fr = !t_ext || t_second;
  wire rel     = t_rd && data_fr && !in_pre && (fidx <= 5'd17);
  wire samp    = tick && !phase && rel && (fidx <= 5'd15);
  wire last    = tick && phase && (bc == '0);
  wire finish  = last && data_fr;

  always_comb begin
    if (!t_ext)
      fw = {2'b01, t_rd ? 2'b10 : 2'b01, 5'd0, t_reg, 2'b10, t_wd};
    else if (!t_second)
      fw = {2'b00, 2'b00, 5'd0, t_dev, 2'b10, t_xreg};
    else
      fw = {2'b00, t_rd ? 2'b11 : 2'b01, 5'd0, t_dev, 2'b10, t_wd};
  end

  assign mdio_oe = busy_q && !rel;
  assign mdio_o  = busy_q && (in_pre || fw[fidx]);

  assign ctrl_rdata = {1'b0, ext_q, post_q, ap_q, busy_q, cs_q, start_q,
                       sup_q, rd_q, reg_q, data_q};
  assign ext_rdata  = {6'd0, port_q, dev_q, xreg_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q <= '0;
      dev_q  <= '0;
      xreg_q <= '0;
    end else if (ext_we) begin
      port_q <= ext_wdata[25:21];
      dev_q  <= ext_wdata[20:16];
      xreg_q <= ext_wdata[15:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0; reg_q <= '0; rd_q <= 1'b0; sup_q <= 1'b0;
      cs_q <= '0; ap_q <= 1'b0; post_q <= 1'b0; ext_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      if (ctrl_we) begin
        data_q <= ctrl_wdata[15:0];
        reg_q  <= ctrl_wdata[20:16];
        rd_q   <= ctrl_wdata[21];
        sup_q  <= ctrl_wdata[22];
        cs_q   <= ctrl_wdata[26:24];
        ap_q   <= ctrl_wdata[28];
        post_q <= ctrl_wdata[29];
        ext_q  <= ctrl_wdata[30];
      end else if (finish && t_rd) begin
        data_q <= rsh;
      end
      if (ctrl_we)     start_q <= ctrl_wdata[23];
      else if (go_sw)  start_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; mdc <= 1'b0; phase <= 1'b0; dcnt <= '0; bc <= '0;
      t_rd <= 1'b0; t_ext <= 1'b0; t_sup <= 1'b0; t_second <= 1'b0;
      t_reg <= '0; t_dev <= '0; t_xreg <= '0; t_wd <= '0; t_half <= 7'd2;
      rsh <= '0;
    end else if (launch) begin
      busy_q   <= 1'b1;
      mdc      <= 1'b0;
      phase    <= 1'b0;
      t_rd     <= go_sw ? rd_q : 1'b1;
      t_ext    <= go_sw ? ext_q : 1'b0;
      t_reg    <= go_sw ? reg_q : 5'd1;
      t_sup    <= sup_q;
      t_second <= 1'b0;
      t_dev    <= dev_q;
      t_xreg   <= xreg_q;
      t_wd     <= data_q;
      t_half   <= half_of(cs_q);
      dcnt     <= half_of(cs_q) - 7'd1;
      bc       <= sup_q ? LAST_S : LAST_L;
    end else if (busy_q) begin
      if (!tick) begin
        dcnt <= dcnt - 7'd1;
      end else begin
        dcnt <= t_half - 7'd1;
        if (!phase) begin
          mdc   <= 1'b1;
          phase <= 1'b1;
          if (samp) rsh <= {rsh[14:0], mdio_i};
        end else begin
          mdc   <= 1'b0;
          phase <= 1'b0;
          if (finish) begin
            busy_q <= 1'b0;
          end else if (last) begin
            t_second <= 1'b1;
            bc       <= t_sup ? LAST_S : LAST_L;
          end else begin
            bc <= bc - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ctrl_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  wire busy  = ctrl_rdata[27];
  wire start = ctrl_rdata[23];

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_rise_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  assert_change_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> !mdc);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdio_oe && !mdc));

  assert_mdc_needs_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> busy);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_rdata(ctrl_rdata),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_we = 1'b0, ext_we = 1'b0;
  logic [31:0] ctrl_wdata = '0, ext_wdata = '0;
  logic [31:0] ctrl_rdata, ext_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i;

  always #2.5 clk = ~clk;

  mdio_master dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ext_we(ext_we), .ext_wdata(ext_wdata), .ctrl_rdata(ctrl_rdata),
    .ext_rdata(ext_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  // simple PHY responder
  logic        phy_drv = 1'b1;
  logic [15:0] phy_val = '0;
  int          relcnt = 0;
  logic [127:0] cap = '0;
  int          ncap = 0;
  assign mdio_i = mdio_oe ? mdio_o : phy_drv;

  always @(posedge mdc) begin
    if (mdio_oe) begin
      cap    <= {cap[126:0], mdio_o};
      ncap   <= ncap + 1;
      relcnt <= 0;
    end else begin
      relcnt <= relcnt + 1;
    end
  end
  always @(negedge mdc)
    phy_drv <= (relcnt >= 2 && relcnt < 18) ? phy_val[4'(17 - relcnt)] : 1'b1;

  int nchk = 0, nfail = 0;

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic check_frame(input string req, input int n0, input int nexp, input logic [127:0] exp);
    logic [127:0] mask;
    mask = (128'd1 << nexp) - 128'd1;
    check({req, " bit count"}, ncap - n0, nexp);
    check({req, " bits"}, cap & mask, exp);
  endtask

  task automatic wr_ctrl(input logic [31:0] w);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = w;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wr_ext(input logic [31:0] w);
    @(negedge clk); ext_we = 1'b1; ext_wdata = w;
    @(negedge clk); ext_we = 1'b0;
  endtask

  task automatic run(input logic [31:0] w, output int bcyc, output int per,
                     output logic [31:0] ra, output logic [31:0] rb);
    int t, r1, r2;
    logic pm;
    bcyc = 0; r1 = -1; r2 = -1; pm = 1'b0; t = 0;
    wr_ctrl(w);
    ra = ctrl_rdata;
    rb = '0;
    do begin
      @(negedge clk);
      t++;
      if (t == 1) rb = ctrl_rdata;
      if (ctrl_rdata[27]) bcyc++;
      if (mdc && !pm) begin
        if (r1 < 0) r1 = t; else if (r2 < 0) r2 = t;
      end
      pm = mdc;
    end while ((ctrl_rdata[27] || ctrl_rdata[23]) && t < 40000);
    per = r2 - r1;
  endtask

  localparam int NV = 8;
  localparam int DIVS [NV] = '{4, 4, 6, 8, 10, 32, 64, 128};

  localparam logic [31:0] SUP = 32'h0040_0000;
  localparam logic [31:0] GO  = 32'h0080_0000;
  localparam logic [31:0] RD  = 32'h0020_0000;
  localparam logic [31:0] EXT = 32'h4000_0000;
  localparam logic [31:0] AP  = 32'h1000_0000;

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int bc, per, n0;
    logic [31:0] ra, rb;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ctrl", ctrl_rdata, 0);
    check("R1 ext", ext_rdata, 0);
    check("R1 mdc/oe", {mdc, mdio_oe}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 field readback
    wr_ctrl(32'h2372_1234);
    check("R2 readback", ctrl_rdata, 32'h2372_1234);
    wr_ctrl(32'h0);

    // R3 divider table walk, R4 plain write frame
    for (int i = 0; i < NV; i++) begin
      n0 = ncap;
      run(SUP | GO | (32'(i) << 24) | (32'd5 << 16) | 32'hA5C3, bc, per, ra, rb);
      check($sformatf("R3 period code %0d", i), per, DIVS[i]);
      check($sformatf("R3 busy length code %0d", i), bc, 32 * DIVS[i]);
      if (i == 0) begin
        check("R2 start set busy clear", {ra[23], ra[27]}, 2'b10);
        check("R2 start clear busy set", {rb[23], rb[27]}, 2'b01);
        check_frame("R4 write", n0, 32, {2'b01, 2'b01, 5'd0, 5'd5, 2'b10, 16'hA5C3});
      end
    end

    // R5 plain read
    phy_val = 16'h3C5A;
    n0 = ncap;
    run(SUP | GO | RD | (32'd9 << 16), bc, per, ra, rb);
    check_frame("R5 read", n0, 14, {2'b01, 2'b10, 5'd0, 5'd9});
    check("R5 data", ctrl_rdata[15:0], 16'h3C5A);

    // R6 preamble present
    n0 = ncap;
    run(GO | (32'd2 << 16) | 32'h1234, bc, per, ra, rb);
    check_frame("R6 preamble", n0, 64, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd0, 5'd2, 2'b10, 16'h1234});
    check("R6 busy length", bc, 64 * 4);

    // R7 extended write
    wr_ext({6'd0, 5'h1F, 5'd3, 16'h8001});
    check("R7 ext readback", ext_rdata, {6'd0, 5'h1F, 5'd3, 16'h8001});
    n0 = ncap;
    run(EXT | SUP | GO | 32'hBEEF, bc, per, ra, rb);
    check_frame("R7 ext write", n0, 64,
      {2'b00, 2'b00, 5'd0, 5'd3, 2'b10, 16'h8001, 2'b00, 2'b01, 5'd0, 5'd3, 2'b10, 16'hBEEF});

    // R8 extended read
    phy_val = 16'h0F0F;
    n0 = ncap;
    run(EXT | SUP | GO | RD, bc, per, ra, rb);
    check_frame("R8 ext read", n0, 46,
      {2'b00, 2'b00, 5'd0, 5'd3, 2'b10, 16'h8001, 2'b00, 2'b11, 5'd0, 5'd3});
    check("R8 data", ctrl_rdata[15:0], 16'h0F0F);

    // R9 auto-poll
    phy_val = 16'h7A31;
    n0 = ncap;
    wr_ctrl(AP | SUP);
    repeat (600) @(negedge clk);
    check("R9 polls seen", (ncap - n0) >= 28, 1);
    check("R9 poll register", cap[13:0], {2'b01, 2'b10, 5'd0, 5'd1});
    check("R9 poll data", ctrl_rdata[15:0], 16'h7A31);
    wr_ctrl(32'h0);
    for (int k = 0; k < 400 && ctrl_rdata[27]; k++) @(negedge clk);
    check("R9 stopped idle", {ctrl_rdata[27], ctrl_rdata[23]}, 0);
    n0 = ncap;
    repeat (300) @(negedge clk);
    check("R9 no further frames", ncap - n0, 0);
    check("R11 idle pins", {mdc, mdio_oe}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule